// File: doc/BRIEF.md
# Two-Byte Video Register Port

This block is the processor-facing control port of a tile-and-sprite video controller. The processor sees it as two adjacent byte addresses. The lowest address bit selects between the data path and the control path. A control register is loaded with two byte writes to the control address. The value byte comes first. The command byte comes second and names the target register. Eight 8-bit control registers are kept. Register 7 is split into a text colour index and a backdrop (border) colour index, each pointing into a 16-entry palette.

A small bus adapter sits in front of the port. It turns a processor bus with one read/write line, an address-select line and a two-phase clock into separate active-low read and write strobes. A strobe is only produced during the second clock phase. The port samples those strobes on its own system clock. It commits write data when the write strobe deasserts, using the value last held on the bus while the strobe was low. A control-path read returns a fixed status byte. The port drives its data outputs only while the read strobe is active.

Top module: `vcp_port`

## Requirements
- R1: While reset is held and after it is released, every register reads 0, both colour outputs are 0, the read-data enable is 0, and the next control-path write is taken as a value byte.
- R2: A value byte followed by a command byte, both written with MODE (address bit 0) = 1, loads the value into the register whose index is in command bits 2:0, provided command bit 7 = 1 and bit 6 = 0. For example, 0xFF then 0x87 sets register 7 to 0xFF.
- R3: Register 7 drives the text colour output from bits 7:4 and the backdrop colour output from bits 3:0. Register i appears on regs_flat[8i+7:8i].
- R4: A command byte whose bits 7:6 are not 1,0 changes no register, and the next control-path write is again taken as a value byte.
- R5: A write with MODE = 0 changes no register and makes the next control-path write a value byte.
- R6: Any completed read strobe makes the next control-path write a value byte.
- R7: While the read strobe is active, cpu_dout is the status stub 0x1F when MODE = 1 and 0x00 when MODE = 0.
- R8: cpu_dout_oe is 1 only while the read strobe is active: select low, cpu_rnw high and cpu_phi2 high. It is 0 when both strobes are inactive and during writes.
- R9: A write strobe exists only when select is low, cpu_rnw is low and cpu_phi2 is high. Bus activity that fails any of these three conditions changes no register.
- R10: The byte committed by a write is the one on cpu_din at the last system-clock edge before the strobe deasserts. Earlier values in the same phase, and values after the strobe ends, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel_n | input | 1 | Address decode of the port, active low |
| cpu_rnw | input | 1 | Processor read/write line, 1 = read |
| cpu_phi2 | input | 1 | Processor clock, high in the second phase |
| cpu_a0 | input | 1 | Lowest address bit, used as MODE |
| cpu_din | input | 8 | Processor write data |
| cpu_dout | output | 8 | Read data toward the processor |
| cpu_dout_oe | output | 1 | Drive enable for cpu_dout; 0 means tri-stated |
| text_color | output | 4 | Text colour palette index |
| backdrop_color | output | 4 | Backdrop and border colour palette index |
| regs_flat | output | 64 | All eight control registers, register i at bits 8i+7:8i |

## Verification
Two events can land in the same few system cycles: the commit of a completed register pair, and a read that clears the byte-pair sequence and drives the status stub. The bench provokes this by issuing a read immediately after a command byte, with no idle gap, so the read strobe rises while the write is still passing through the strobe synchroniser. It then checks three things: the status byte and drive enable seen during the read, the colour outputs after the commit, and that a following value/command pair is still taken in the right order.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

  typedef enum logic {
    SEQ_VALUE   = 1'b0,
    SEQ_COMMAND = 1'b1
  } seq_state_e;

  // Command byte: top two bits 1,0 request a register load.
  function automatic logic is_reg_load(input logic [7:0] cmd);
    return (cmd[7:6] == 2'b10);
  endfunction

endpackage

// File: rtl/vcp_bus_adapter.sv
module vcp_bus_adapter (
  input  logic cpu_sel_n,
  input  logic cpu_rnw,
  input  logic cpu_phi2,
  input  logic cpu_a0,
  output logic wr_n,
  output logic rd_n,
  output logic mode
);

  logic phase1_n;

  // Active-low terms joined with OR behave as an AND of the assertions.
  assign phase1_n = ~cpu_phi2;
  assign wr_n     = cpu_sel_n | cpu_rnw  | phase1_n;
  assign rd_n     = cpu_sel_n | ~cpu_rnw | phase1_n;
  assign mode     = cpu_a0;

endmodule

// File: rtl/vcp_strobe_sync.sv
module vcp_strobe_sync #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              mode,
  input  logic [DATA_W-1:0] din,
  output logic              wr_end,
  output logic              rd_end,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_mode
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0]   wr_sh_q, wr_sh_d;
  logic [SH_W-1:0]   rd_sh_q, rd_sh_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              mode_q, mode_d;

  always_comb begin
    wr_sh_d = {wr_sh_q[SH_W-2:0], wr_n};
    rd_sh_d = {rd_sh_q[SH_W-2:0], rd_n};
    data_d  = data_q;
    mode_d  = mode_q;
    if (!wr_n) begin
      data_d = din;
      mode_d = mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sh_q <= '1;
      rd_sh_q <= '1;
      data_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      wr_sh_q <= wr_sh_d;
      rd_sh_q <= rd_sh_d;
      data_q  <= data_d;
      mode_q  <= mode_d;
    end
  end

  // Deassertion (low to high) seen at the output of the synchroniser.
  assign wr_end   = wr_sh_q[SH_W-2] & ~wr_sh_q[SH_W-1];
  assign rd_end   = rd_sh_q[SH_W-2] & ~rd_sh_q[SH_W-1];
  assign cap_data = data_q;
  assign cap_mode = mode_q;

endmodule

// File: rtl/vcp_pair_seq.sv
module vcp_pair_seq
  import vcp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_end,
  input  logic              rd_end,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              cap_mode,
  output logic              commit,
  output logic [IDX_W-1:0]  commit_idx,
  output logic [DATA_W-1:0] commit_data,
  output logic              pending
);

  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_en;

  always_comb begin
    state_d = state_q;
    hold_en = 1'b0;
    commit  = 1'b0;
    if (rd_end) begin
      state_d = SEQ_VALUE;
    end else if (wr_end) begin
      if (!cap_mode) begin
        state_d = SEQ_VALUE;
      end else if (state_q == SEQ_VALUE) begin
        state_d = SEQ_COMMAND;
        hold_en = 1'b1;
      end else begin
        state_d = SEQ_VALUE;
        commit  = is_reg_load(cap_data[DATA_W-1 -: 8]);
      end
    end
    hold_d = hold_en ? cap_data : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_VALUE;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
    end
  end

  assign commit_idx  = cap_data[IDX_W-1:0];
  assign commit_data = hold_q;
  assign pending     = (state_q == SEQ_COMMAND);

endmodule

// File: rtl/vcp_regfile.sv
module vcp_regfile #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           widx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] r_q, r_d;
    logic              r_en;

    always_comb begin
      r_en = we && (widx == IDX_W'(i));
      r_d  = r_en ? wdata : r_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else        r_q <= r_d;
    end

    assign regs_flat[i*DATA_W +: DATA_W] = r_q;
  end

endmodule

// File: rtl/vcp_port.sv
module vcp_port #(
  parameter int          DATA_W      = 8,
  parameter int          NUM_REGS    = 8,
  parameter int          COLOR_W     = 4,
  parameter int          COLOR_REG   = 7,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  STATUS_STUB = 8'h1F
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_sel_n,
  input  logic                       cpu_rnw,
  input  logic                       cpu_phi2,
  input  logic                       cpu_a0,
  input  logic [DATA_W-1:0]          cpu_din,
  output logic [DATA_W-1:0]          cpu_dout,
  output logic                       cpu_dout_oe,
  output logic [COLOR_W-1:0]         text_color,
  output logic [COLOR_W-1:0]         backdrop_color,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              wr_n, rd_n, mode;
  logic              wr_end, rd_end, cap_mode;
  logic [DATA_W-1:0] cap_data;
  logic              seq_commit, seq_pending;
  logic [IDX_W-1:0]  seq_idx;
  logic [DATA_W-1:0] seq_data;
  logic [DATA_W-1:0] color_reg;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  vcp_bus_adapter u_adapter (
    .cpu_sel_n (cpu_sel_n),
    .cpu_rnw   (cpu_rnw),
    .cpu_phi2  (cpu_phi2),
    .cpu_a0    (cpu_a0),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .mode      (mode)
  );

  vcp_strobe_sync #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .mode     (mode),
    .din      (cpu_din),
    .wr_end   (wr_end),
    .rd_end   (rd_end),
    .cap_data (cap_data),
    .cap_mode (cap_mode)
  );

  vcp_pair_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_end      (wr_end),
    .rd_end      (rd_end),
    .cap_data    (cap_data),
    .cap_mode    (cap_mode),
    .commit      (seq_commit),
    .commit_idx  (seq_idx),
    .commit_data (seq_data),
    .pending     (seq_pending)
  );

  vcp_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we        (seq_commit),
    .widx      (seq_idx),
    .wdata     (seq_data),
    .regs_flat (regs_flat)
  );

  assign color_reg      = regs_flat[COLOR_REG*DATA_W +: DATA_W];
  assign text_color     = color_reg[2*COLOR_W-1:COLOR_W];
  assign backdrop_color = color_reg[COLOR_W-1:0];

  assign cpu_dout_oe = ~rd_n;
  assign cpu_dout    = (!rd_n && mode) ? DATA_W'(STATUS_STUB) : '0;

endmodule

// File: rtl/vcp_port_chk.sv
module vcp_port_chk #(
  parameter int         DATA_W      = 8,
  parameter int         NUM_REGS    = 8,
  parameter logic [7:0] STATUS_STUB = 8'h1F
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cpu_sel_n,
  input logic                       cpu_rnw,
  input logic                       cpu_phi2,
  input logic                       cpu_a0,
  input logic [DATA_W-1:0]          cpu_dout,
  input logic                       cpu_dout_oe,
  input logic [NUM_REGS*DATA_W-1:0] regs_flat,
  input logic                       wr_end,
  input logic                       rd_end,
  input logic                       cap_mode,
  input logic [DATA_W-1:0]          cap_data,
  input logic                       seq_commit,
  input logic                       seq_pending
);

  // R2
  regs_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_flat) |-> $past(seq_commit));

  // R4
  bad_cmd_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && cap_mode && seq_pending && (cap_data[DATA_W-1 -: 2] != 2'b10))
      |=> ($stable(regs_flat) && !seq_pending));

  // R5
  mode_low_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && !cap_mode) |=> !seq_pending);

  // R6
  read_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end |=> !seq_pending);

  // R7
  stub_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_dout_oe && cpu_a0) |-> (cpu_dout == DATA_W'(STATUS_STUB)));

  // R8
  drive_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_dout_oe |-> (!cpu_sel_n && cpu_rnw && cpu_phi2));

endmodule

bind vcp_port vcp_port_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .STATUS_STUB(STATUS_STUB)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cpu_sel_n   (cpu_sel_n),
  .cpu_rnw     (cpu_rnw),
  .cpu_phi2    (cpu_phi2),
  .cpu_a0      (cpu_a0),
  .cpu_dout    (cpu_dout),
  .cpu_dout_oe (cpu_dout_oe),
  .regs_flat   (regs_flat),
  .wr_end      (wr_end),
  .rd_end      (rd_end),
  .cap_mode    (cap_mode),
  .cap_data    (cap_data),
  .seq_commit  (seq_commit),
  .seq_pending (seq_pending)
);

// File: tb/vcp_port_tb.sv
module vcp_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 6;
  // {value, command}
  localparam logic [15:0] VEC [NVEC] = '{
    16'hFF87, 16'h4C87, 16'h1247, 16'h34C7, 16'hA580, 16'h6983
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_sel_n, cpu_rnw, cpu_phi2, cpu_a0;
  logic [7:0]  cpu_din;
  logic [7:0]  cpu_dout;
  logic        cpu_dout_oe;
  logic [3:0]  text_color, backdrop_color;
  logic [63:0] regs_flat;

  int          n_run  = 0;
  int          n_fail = 0;
  logic [7:0]  model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  vcp_port u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_sel_n      (cpu_sel_n),
    .cpu_rnw        (cpu_rnw),
    .cpu_phi2       (cpu_phi2),
    .cpu_a0         (cpu_a0),
    .cpu_din        (cpu_din),
    .cpu_dout       (cpu_dout),
    .cpu_dout_oe    (cpu_dout_oe),
    .text_color     (text_color),
    .backdrop_color (backdrop_color),
    .regs_flat      (regs_flat)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic check_model(input string tag);
    check(tag, regs_flat, model_flat());
    check({tag, " text"}, 64'(text_color), 64'(model[7][7:4]));
    check({tag, " backdrop"}, 64'(backdrop_color), 64'(model[7][3:0]));
  endtask

  // One processor bus cycle; samples the read side late in phase 2.
  task automatic bus(input logic sel_n, input logic rnw, input logic ph, input logic a0,
                     input logic [7:0] early, input logic [7:0] data, input logic [7:0] late,
                     input int gap, output logic [7:0] rdat, output logic roe);
    @(negedge clk);
    cpu_sel_n = sel_n; cpu_rnw = rnw; cpu_a0 = a0; cpu_din = early; cpu_phi2 = 1'b0;
    @(negedge clk); cpu_phi2 = ph;
    @(negedge clk);
    @(negedge clk); cpu_din = data;
    @(negedge clk); #1; rdat = cpu_dout; roe = cpu_dout_oe;
    @(negedge clk); cpu_phi2 = 1'b0; cpu_din = late;
    @(negedge clk); cpu_sel_n = 1'b1; cpu_rnw = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic wr(input logic a0, input logic [7:0] d);
    logic [7:0] r; logic o;
    bus(1'b0, 1'b0, 1'b1, a0, ~d, d, ~d, 4, r, o);
  endtask

  task automatic pair(input logic [7:0] val, input logic [7:0] cmd);
    wr(1'b1, val);
    wr(1'b1, cmd);
    if (cmd[7:6] == 2'b10) model[cmd[2:0]] = val;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       oe;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    rst_n = 1'b0; cpu_sel_n = 1'b1; cpu_rnw = 1'b1; cpu_phi2 = 1'b0;
    cpu_a0 = 1'b0; cpu_din = 8'h00;
    repeat (3) @(negedge clk);
    // R1 state in and after reset
    check("R1 oe in reset", 64'(cpu_dout_oe), 64'd0);
    check_model("R1 regs in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_model("R1 regs after reset");
    check("R1 oe idle", 64'(cpu_dout_oe), 64'd0);

    // R2 R3 R4 vector table
    for (int v = 0; v < NVEC; v++) begin
      pair(VEC[v][15:8], VEC[v][7:0]);
      check_model($sformatf("R2 R3 R4 vector %0d", v));
    end
    check("R3 after vectors reg7", 64'(regs_flat[63:56]), 64'h4C);

    // R2 canonical white border
    pair(8'hFF, 8'h87);
    check("R2 text white", 64'(text_color), 64'hF);
    check("R2 backdrop white", 64'(backdrop_color), 64'hF);

    // R5 MODE-low write between value and command
    wr(1'b1, 8'hEE);
    wr(1'b0, 8'h00);
    check_model("R5 mode-low write no change");
    pair(8'h3C, 8'h87);
    check_model("R5 realigned pair");

    // R6 read between value and command
    wr(1'b1, 8'h11);
    bus(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 4, rd, oe);
    pair(8'h5B, 8'h87);
    check_model("R6 realigned after read");

    // R7 status stub and data-path read
    bus(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 4, rd, oe);
    check("R7 status stub", 64'(rd), 64'h1F);
    check("R8 oe during read", 64'(oe), 64'd1);
    bus(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 4, rd, oe);
    check("R7 mode-low read", 64'(rd), 64'h00);

    // R8 no drive during a write
    bus(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 4, rd, oe);
    check("R8 oe during write", 64'(oe), 64'd0);

    // R9 writes failing one strobe condition
    bus(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h77, 8'h00, 4, rd, oe);
    bus(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h87, 8'h00, 4, rd, oe);
    check_model("R9 deselected pair");
    bus(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h77, 8'h00, 4, rd, oe);
    bus(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h87, 8'h00, 4, rd, oe);
    check_model("R9 phase-1 only pair");
    check("R9 oe phase-1 only", 64'(oe), 64'd0);

    // R10 last value before strobe end wins
    bus(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'hE1, 8'h99, 4, rd, oe);
    bus(1'b0, 1'b0, 1'b1, 1'b1, 8'h02, 8'h87, 8'h03, 4, rd, oe);
    model[7] = 8'hE1;
    check_model("R10 capture at strobe end");

    // Commit and read back to back
    wr(1'b1, 8'hD2);
    bus(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h87, 8'h00, 0, rd, oe);
    model[7] = 8'hD2;
    bus(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 4, rd, oe);
    check("R7 stub right after commit", 64'(rd), 64'h1F);
    check_model("R2 commit overlapping read");
    pair(8'h9A, 8'h83);
    check_model("R6 pair after overlap");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule